// File: doc/BRIEF.md
# Single-Precision / Integer Converter

This block turns a 32-bit single-precision floating-point word into a 32-bit two's-complement integer, or a 32-bit signed integer into single precision. A caller presents an operand, an operation code and a one-cycle start strobe. Exactly one clock later the block raises a one-cycle completion pulse and presents the result together with an invalid flag and an inexact flag. Result and flags then hold until the next start.

Four operation codes convert float to integer with a fixed rounding direction. A fifth takes its direction from a separate two-bit rounding-mode input, which lets it follow a current mode held elsewhere. A sixth converts integer to float. Out-of-range values and NaN saturate and raise the invalid flag. The result of a float-to-integer operation is the raw integer bit pattern.

Top module: `fp_int_convert`

## Requirements
- R1: A start sampled high at a rising clock edge makes done high for exactly the following cycle, with result, invalid and inexact updated at that same edge. Without start, done is 0 and result and flags keep their values.
- R2: op_sel 000 converts float to integer rounding to nearest with ties to even, 001 truncates toward zero, 010 rounds toward +infinity, and 011 rounds toward -infinity. The result is a two's-complement integer.
- R3: op_sel 100 converts float to integer using rnd_mode: 00 nearest-even, 01 toward zero, 10 toward +infinity, 11 toward -infinity.
- R4: A NaN operand (exponent field all ones, nonzero fraction) in any float-to-integer operation gives result 0x7FFFFFFF with invalid set.
- R5: When the rounded value lies outside [-2^31, 2^31-1], which includes infinities, the result saturates to 0x7FFFFFFF for positive and 0x80000000 for negative, with invalid set. -2^31 itself converts exactly with invalid clear.
- R6: Zeros and denormals (exponent field zero) convert to 0. The exceptions are a nonzero positive denormal rounded toward +infinity, which gives 1, and a nonzero negative denormal rounded toward -infinity, which gives 0xFFFFFFFF.
- R7: op_sel 101 treats the operand as a signed 32-bit integer and returns its single-precision encoding. When the magnitude has at most 24 significant bits the conversion is exact and inexact is 0.
- R8: For integer-to-float with more than 24 significant bits, the block rounds to nearest with ties to even and sets inexact. Integer-to-float never sets invalid.
- R9: op_sel 110 and 111 are reserved: result 0, invalid 1, inexact 0.
- R10: While rst_n is low, result is 0 and done, invalid and inexact are 0.
- R11: inexact is 0 after every float-to-integer operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches one conversion |
| op_sel | input | 3 | Operation code (see R2, R3, R7, R9) |
| rnd_mode | input | 2 | Rounding direction for op_sel 100 |
| operand | input | 32 | Float or signed integer source |
| result | output | 32 | Integer or float result |
| done | output | 1 | One-cycle completion pulse |
| invalid | output | 1 | NaN, out-of-range or reserved operation |
| inexact | output | 1 | Integer-to-float lost bits in rounding |

## Verification
Assertions watch the handshake on every cycle: done follows each start and only a start, and the result holds between starts. They also check the flag rules that need no arithmetic. NaN always saturates with invalid set, reserved codes return zero with invalid set, integer-to-float never raises invalid, and float-to-integer never raises inexact. Rounding itself needs directed cases at chosen values, because only those cases can show it. These are ties in both signs, tiny and denormal magnitudes, the largest float below 2^31, exactly -2^31, and integers just past 24 bits.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  localparam int WORD_W = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int SIG_W  = FRAC_W + 1;
  localparam logic [EXP_W-1:0] BIAS_INT0 = 8'd150;  // exponent with no fraction bits
  localparam logic [EXP_W-1:0] EXP_TOP   = 8'd158;  // exponent of 2^31

  typedef enum logic [1:0] {RM_NEAR = 2'b00, RM_ZERO = 2'b01, RM_POS = 2'b10, RM_NEG = 2'b11} rmode_e;

  localparam logic [2:0] OP_CUR = 3'b100;
  localparam logic [2:0] OP_I2F = 3'b101;

  typedef struct packed {
    logic [WORD_W-1:0] value;
    logic              invalid;
  } f2i_res_t;

  typedef struct packed {
    logic [WORD_W-1:0] value;
    logic              inexact;
  } i2f_res_t;

  function automatic logic round_up(input rmode_e rm, input logic neg,
                                    input logic lsb, input logic grd, input logic stk);
    case (rm)
      RM_NEAR: return grd & (stk | lsb);
      RM_ZERO: return 1'b0;
      RM_POS:  return ~neg & (grd | stk);
      default: return neg & (grd | stk);
    endcase
  endfunction

  function automatic f2i_res_t float_to_int(input logic [31:0] f, input rmode_e rm);
    f2i_res_t r;
    logic        neg;
    logic [7:0]  ex;
    logic [23:0] sig;
    logic [31:0] ipart;
    logic [48:0] ext;
    logic        grd, stk, big, inc;
    logic [32:0] mag, lim;
    neg   = f[31];
    ex    = f[30:23];
    sig   = {1'b1, f[22:0]};
    ipart = '0;
    ext   = '0;
    grd   = 1'b0;
    stk   = 1'b0;
    big   = 1'b0;
    if (ex == 8'hFF || ex > EXP_TOP) begin
      big = 1'b1;
    end else if (ex >= BIAS_INT0) begin
      ipart = {8'b0, sig} << (ex - BIAS_INT0);
    end else if (ex >= 8'd125) begin
      ext   = {sig, 25'b0} >> (BIAS_INT0 - ex);
      ipart = {8'b0, ext[48:25]};
      grd   = ext[24];
      stk   = |ext[23:0];
    end else begin
      stk = (ex != 8'd0) || (f[22:0] != 23'd0);
    end
    inc = round_up(rm, neg, ipart[0], grd, stk);
    mag = {1'b0, ipart} + {32'b0, inc};
    lim = neg ? 33'h0_8000_0000 : 33'h0_7FFF_FFFF;
    if (ex == 8'hFF && f[22:0] != 23'd0) begin
      r.value = 32'h7FFF_FFFF;  r.invalid = 1'b1;
    end else if (big || mag > lim) begin
      r.value = neg ? 32'h8000_0000 : 32'h7FFF_FFFF;  r.invalid = 1'b1;
    end else begin
      r.value = neg ? (32'd0 - mag[31:0]) : mag[31:0];  r.invalid = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [4:0] lead_zeros(input logic [31:0] v);
    logic [4:0] n;
    logic       seen;
    n    = '0;
    seen = 1'b0;
    for (int i = 31; i >= 0; i--) begin
      if (!seen) begin
        if (v[i]) seen = 1'b1;
        else      n = n + 5'd1;
      end
    end
    return n;
  endfunction

  function automatic i2f_res_t int_to_float(input logic [31:0] x);
    i2f_res_t   r;
    logic [31:0] mag, norm;
    logic [4:0]  lz;
    logic [7:0]  ex;
    logic        grd, stk, inc;
    logic [30:0] body;
    mag  = x[31] ? (32'd0 - x) : x;
    lz   = lead_zeros(mag);
    norm = mag << lz;
    ex   = EXP_TOP - {3'b0, lz};
    grd  = norm[7];
    stk  = |norm[6:0];
    inc  = grd & (stk | norm[8]);
    body = {ex, norm[30:8]} + {30'b0, inc};
    if (mag == 32'd0) begin
      r.value = '0;  r.inexact = 1'b0;
    end else begin
      r.value = {x[31], body};  r.inexact = grd | stk;
    end
    return r;
  endfunction
endpackage

// File: rtl/cvt_f2i.sv
module cvt_f2i
  import cvt_pkg::*;
(
  input  logic [31:0] src,
  input  rmode_e      rm,
  output logic [31:0] value,
  output logic        invalid,
  output logic        is_nan
);
  f2i_res_t r;
  always_comb r = float_to_int(src, rm);
  assign value   = r.value;
  assign invalid = r.invalid;
  assign is_nan  = (src[30:23] == 8'hFF) && (src[22:0] != 23'd0);
endmodule

// File: rtl/cvt_i2f.sv
module cvt_i2f
  import cvt_pkg::*;
(
  input  logic [31:0] src,
  output logic [31:0] value,
  output logic        inexact
);
  i2f_res_t r;
  always_comb r = int_to_float(src);
  assign value   = r.value;
  assign inexact = r.inexact;
endmodule

// File: rtl/fp_int_convert.sv
module fp_int_convert
  import cvt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  op_sel,
  input  logic [1:0]  rnd_mode,
  input  logic [31:0] operand,
  output logic [31:0] result,
  output logic        done,
  output logic        invalid,
  output logic        inexact
);
  rmode_e      eff_rm;
  logic [31:0] f2i_val, i2f_val;
  logic        f2i_inv, f2i_nan, i2f_inx;
  logic        sel_f2i, sel_i2f, sel_rsv;

  assign sel_f2i = (op_sel[2] == 1'b0) || (op_sel == OP_CUR);
  assign sel_i2f = (op_sel == OP_I2F);
  assign sel_rsv = (op_sel[2:1] == 2'b11);
  assign eff_rm  = (op_sel == OP_CUR) ? rmode_e'(rnd_mode) : rmode_e'(op_sel[1:0]);

  cvt_f2i u_f2i (.src(operand), .rm(eff_rm), .value(f2i_val), .invalid(f2i_inv), .is_nan(f2i_nan));
  cvt_i2f u_i2f (.src(operand), .value(i2f_val), .inexact(i2f_inx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result  <= '0;
      done    <= 1'b0;
      invalid <= 1'b0;
      inexact <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        if (sel_i2f) begin
          result <= i2f_val;  invalid <= 1'b0;  inexact <= i2f_inx;
        end else if (sel_f2i) begin
          result <= f2i_val;  invalid <= f2i_inv;  inexact <= 1'b0;
        end else begin
          result <= '0;  invalid <= 1'b1;  inexact <= 1'b0;
        end
      end
    end
  end

  p_done_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n) start |=> done);
  p_done_only_start_r1: assert property (@(posedge clk) disable iff (!rst_n) !start |=> !done);
  p_hold_result_r1: assert property (@(posedge clk) disable iff (!rst_n) !start |=> $stable(result));
  p_nan_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && sel_f2i && f2i_nan) |=> (invalid && result == 32'h7FFF_FFFF));
  p_i2f_valid_r8: assert property (@(posedge clk) disable iff (!rst_n) (start && sel_i2f) |=> !invalid);
  p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && sel_rsv) |=> (invalid && result == 32'd0 && !inexact));
  p_f2i_exact_flag_r11: assert property (@(posedge clk) disable iff (!rst_n) (start && sel_f2i) |=> !inexact);
endmodule

// File: tb/fp_int_convert_tb_top.sv
`timescale 1ns/1ps
module fp_int_convert_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [1:0]  rnd_mode = '0;
  logic [31:0] operand = '0;
  logic [31:0] result;
  logic        done, invalid, inexact;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fp_int_convert dut_i (.clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .rnd_mode(rnd_mode),
                        .operand(operand), .result(result), .done(done), .invalid(invalid), .inexact(inexact));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [2:0] op, input logic [1:0] rm, input logic [31:0] a,
                     input logic [31:0] exp_res, input logic exp_inv, input logic exp_inx);
    @(negedge clk);
    op_sel = op; rnd_mode = rm; operand = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " R1 done"}, {31'b0, done}, 32'd1);
    check({tag, " result"}, result, exp_res);
    check({tag, " invalid"}, {31'b0, invalid}, {31'b0, exp_inv});
    check({tag, " inexact"}, {31'b0, inexact}, {31'b0, exp_inx});
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R10 result", result, 32'd0);
    check("R10 flags", {29'b0, done, invalid, inexact}, 32'd0);
  endtask

  task automatic t_fixed_modes;
    run("R2 near 2.5", 3'b000, 2'b00, 32'h4020_0000, 32'd2, 0, 0);
    run("R2 near 3.5", 3'b000, 2'b00, 32'h4060_0000, 32'd4, 0, 0);
    run("R2 near 0.5", 3'b000, 2'b00, 32'h3F00_0000, 32'd0, 0, 0);
    run("R2 near -2.5", 3'b000, 2'b00, 32'hC020_0000, 32'hFFFF_FFFE, 0, 0);
    run("R2 near -0.75", 3'b000, 2'b00, 32'hBF40_0000, 32'hFFFF_FFFF, 0, 0);
    run("R2 trunc 2.5", 3'b001, 2'b00, 32'h4020_0000, 32'd2, 0, 0);
    run("R2 trunc -0.75", 3'b001, 2'b00, 32'hBF40_0000, 32'd0, 0, 0);
    run("R2 ceil 2.5", 3'b010, 2'b00, 32'h4020_0000, 32'd3, 0, 0);
    run("R2 ceil -2.5", 3'b010, 2'b00, 32'hC020_0000, 32'hFFFF_FFFE, 0, 0);
    run("R2 floor 2.5", 3'b011, 2'b00, 32'h4020_0000, 32'd2, 0, 0);
    run("R2 floor -2.5", 3'b011, 2'b00, 32'hC020_0000, 32'hFFFF_FFFD, 0, 0);
  endtask

  task automatic t_current_mode;
    run("R3 cur near", 3'b100, 2'b00, 32'h3FC0_0000, 32'd2, 0, 0);
    run("R3 cur zero", 3'b100, 2'b01, 32'hC020_0000, 32'hFFFF_FFFE, 0, 0);
    run("R3 cur pos", 3'b100, 2'b10, 32'h4020_0000, 32'd3, 0, 0);
    run("R3 cur neg", 3'b100, 2'b11, 32'hC020_0000, 32'hFFFF_FFFD, 0, 0);
  endtask

  task automatic t_special;
    run("R4 nan", 3'b001, 2'b00, 32'h7FC0_0000, 32'h7FFF_FFFF, 1, 0);
    run("R4 neg nan", 3'b011, 2'b00, 32'hFF80_0001, 32'h7FFF_FFFF, 1, 0);
    run("R5 +inf", 3'b000, 2'b00, 32'h7F80_0000, 32'h7FFF_FFFF, 1, 0);
    run("R5 -inf", 3'b000, 2'b00, 32'hFF80_0000, 32'h8000_0000, 1, 0);
    run("R5 2^31", 3'b001, 2'b00, 32'h4F00_0000, 32'h7FFF_FFFF, 1, 0);
    run("R5 -2^31", 3'b001, 2'b00, 32'hCF00_0000, 32'h8000_0000, 0, 0);
    run("R5 max below", 3'b000, 2'b00, 32'h4EFF_FFFF, 32'h7FFF_FF80, 0, 0);
    run("R5 -2^32", 3'b010, 2'b00, 32'hCF80_0000, 32'h8000_0000, 1, 0);
  endtask

  task automatic t_denormal;
    run("R6 zero ceil", 3'b010, 2'b00, 32'h0000_0000, 32'd0, 0, 0);
    run("R6 den near", 3'b000, 2'b00, 32'h0000_0001, 32'd0, 0, 0);
    run("R6 den ceil", 3'b010, 2'b00, 32'h0000_0001, 32'd1, 0, 0);
    run("R6 den floor", 3'b011, 2'b00, 32'h0000_0001, 32'd0, 0, 0);
    run("R6 nden floor", 3'b011, 2'b00, 32'h8000_0001, 32'hFFFF_FFFF, 0, 0);
    run("R6 nden ceil", 3'b010, 2'b00, 32'h8000_0001, 32'd0, 0, 0);
  endtask

  task automatic t_i2f;
    run("R7 one", 3'b101, 2'b11, 32'd1, 32'h3F80_0000, 0, 0);
    run("R7 zero", 3'b101, 2'b00, 32'd0, 32'd0, 0, 0);
    run("R7 minus2", 3'b101, 2'b00, 32'hFFFF_FFFE, 32'hC000_0000, 0, 0);
    run("R7 min int", 3'b101, 2'b00, 32'h8000_0000, 32'hCF00_0000, 0, 0);
    run("R8 tie even", 3'b101, 2'b00, 32'h0100_0001, 32'h4B80_0000, 0, 1);
    run("R8 tie odd", 3'b101, 2'b00, 32'h0100_0003, 32'h4B80_0002, 0, 1);
    run("R8 max int", 3'b101, 2'b00, 32'h7FFF_FFFF, 32'h4F00_0000, 0, 1);
  endtask

  task automatic t_reserved;
    run("R9 op110", 3'b110, 2'b00, 32'h4020_0000, 32'd0, 1, 0);
    run("R9 op111", 3'b111, 2'b00, 32'h0100_0001, 32'd0, 1, 0);
    run("R11 after i2f inexact", 3'b000, 2'b00, 32'h4040_0000, 32'd3, 0, 0);
  endtask

  task automatic t_hold;
    run("R1 setup", 3'b000, 2'b00, 32'h40A0_0000, 32'd5, 0, 0);
    operand = 32'h7FC0_0000; op_sel = 3'b110;
    repeat (3) @(negedge clk);
    check("R1 done low", {31'b0, done}, 32'd0);
    check("R1 hold", result, 32'd5);
    check("R1 flags hold", {30'b0, invalid, inexact}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_fixed_modes();
    t_current_mode();
    t_special();
    t_denormal();
    t_i2f();
    t_reserved();
    t_hold();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule